// File: doc/BRIEF.md
# Local-History Branch Direction Predictor with Cached Guess

This block predicts whether conditional branches will be taken. It uses two levels of tables. The fetch address selects a per-branch entry in a history table. That entry holds the branch's recent taken/not-taken outcomes. The history value then selects a 2-bit saturating counter in a shared pattern table. A history table followed by a pattern table would need two serial reads in the fetch cycle. To avoid this, every history entry also stores one extra bit: the counter prediction it produced last time. Fetch receives this cached bit in the same cycle as the address, so it can steer without waiting.

The history value and the cached bit are registered together. In the next cycle, the pattern-table counter for that history is read, and its prediction is compared with the cached bit. When the two differ, the block raises an override in that cycle so the pipeline can flush after the branch. The pipeline then continues along the counter's direction.

When a branch resolves, the counter picked by its current history is trained toward the outcome. The outcome is then shifted into that branch's history. The cached bit is refreshed with the prediction for the new history.

Top module: `lhist_predictor`

## Requirements
- R1: After synchronous reset, all histories are zero and all counters are weakly not-taken (binary 01). Every fetch lookup therefore returns a not-taken guess, a not-taken check result and no override.
- R2: The history entry is selected by address bits `[PC_OFS +: IDX_W]` (bits 5..2 by default); all other address bits have no effect. `fetch_guess` is the cached bit of that entry, valid in the same cycle as `fetch_pc`.
- R3: `check_valid` is high exactly in the cycle after a cycle with `fetch_valid` high. In that cycle, `check_taken` is the prediction of the counter selected by the history that the entry held at lookup.
- R4: `override` is high exactly when `check_valid` is high and `check_taken` differs from the `fetch_guess` given one cycle earlier.
- R5: A counter predicts taken when its upper bit is 1 (values 10 and 11) and not-taken for 00 and 01. On training, it increments on taken and decrements on not-taken, and it saturates at 11 and 00.
- R6: On resolution, the outcome (1 = taken) enters the history's least significant bit, the other bits move up one place, and the oldest bit is dropped.
- R7: The counter trained on a resolution is the one selected by the history before that resolution's shift.
- R8: On resolution, the entry's cached bit becomes the prediction of the counter at the new history, taking into account the training done by the same resolution.
- R9: The pattern table is shared by history value. Training done by one branch changes the check result of any other branch whose history selects the same counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A lookup is presented this cycle |
| fetch_pc | input | ADDR_W | Address of the branch being fetched |
| fetch_guess | output | 1 | Cached prediction for `fetch_pc`, same cycle (1 = taken) |
| check_valid | output | 1 | Pattern-table check result is valid this cycle |
| check_taken | output | 1 | Counter-based prediction for the previous cycle's lookup |
| override | output | 1 | Check disagrees with the earlier guess; flush after the branch |
| resolve_valid | input | 1 | A branch outcome is presented this cycle |
| resolve_pc | input | ADDR_W | Address of the resolving branch |
| resolve_taken | input | 1 | Resolved outcome (1 = taken) |

## Verification
The hardest case to reach is a disagreement between the cached bit and the counter. A branch's own resolution always leaves its cached bit in agreement with the counter it points at. A mismatch therefore appears only after a different branch, whose history selects the same counter, trains that counter across the taken/not-taken boundary. The bench creates this on purpose: one branch resolves from history zero while a second branch still sits at history zero, and the second branch is then looked up. A long sweep then interleaves lookups and resolutions over all sixteen entries, with varied upper and offset address bits. Its outcome stream comes from a shift-register sequence that keeps many histories colliding. Every guess, check and override is compared against an arithmetic table model kept in the bench.

// File: rtl/lhp_pkg.sv
package lhp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_STRONG_NT = 2'b00;
    localparam ctr_t CTR_WEAK_NT   = 2'b01;
    localparam ctr_t CTR_STRONG_T  = 2'b11;

    // Saturating step of a 2-bit direction counter.
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        if (taken) begin
            nxt = (cur == CTR_STRONG_T) ? cur : cur + 2'd1;
        end else begin
            nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
        end
        return nxt;
    endfunction

    // Upper half of the counter range means taken.
    function automatic logic ctr_taken(input ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/lhp_hist_table.sv
module lhp_hist_table
    import lhp_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    // fetch-side read port
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    output logic              rd_guess,
    // resolve-side read port
    input  logic [IDX_W-1:0]  up_idx,
    output logic [HIST_W-1:0] up_hist,
    // update port
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_taken,
    input  logic              wr_guess
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [HIST_W-1:0] hist_q  [ENTRIES];
    logic              guess_q [ENTRIES];

    assign rd_hist  = hist_q[rd_idx];
    assign rd_guess = guess_q[rd_idx];
    assign up_hist  = hist_q[up_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                hist_q[i]  <= '0;
                guess_q[i] <= ctr_taken(CTR_WEAK_NT);
            end
        end else if (wr_en) begin
            hist_q[wr_idx]  <= {hist_q[wr_idx][HIST_W-2:0], wr_taken};
            guess_q[wr_idx] <= wr_guess;
        end
    end

    // R6: newest outcome lands in the low history bit
    assert_hist_newest_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> hist_q[$past(wr_idx)][0] == $past(wr_taken));

    // R6: older outcomes move up by one place
    assert_hist_shift_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> hist_q[$past(wr_idx)][HIST_W-1:1] == $past(up_hist[HIST_W-2:0]) || $past(up_idx) != $past(wr_idx));

    // R8: cached bit holds the refreshed guess after an update
    assert_guess_refresh_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> guess_q[$past(wr_idx)] == $past(wr_guess));

endmodule

// File: rtl/lhp_pattern_table.sv
module lhp_pattern_table
    import lhp_pkg::*;
#(
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    // check-stage read port
    input  logic [HIST_W-1:0] chk_idx,
    output ctr_t              chk_ctr,
    // training read port (pre-update history)
    input  logic [HIST_W-1:0] old_idx,
    output ctr_t              old_ctr,
    // refresh read port (post-update history)
    input  logic [HIST_W-1:0] new_idx,
    output ctr_t              new_ctr,
    // training write
    input  logic              train_en,
    input  logic              train_taken
);
    localparam int ENTRIES = 1 << HIST_W;

    ctr_t ctr_q [ENTRIES];

    assign chk_ctr = ctr_q[chk_idx];
    assign old_ctr = ctr_q[old_idx];
    assign new_ctr = ctr_q[new_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ctr_q[i] <= CTR_WEAK_NT;
            end
        end else if (train_en) begin
            ctr_q[old_idx] <= ctr_step(ctr_q[old_idx], train_taken);
        end
    end

    // R5: a taken outcome never leaves the counter at the bottom
    assert_taken_leaves_floor_R5: assert property (@(posedge clk) disable iff (rst)
        (train_en && train_taken) |=> ctr_q[$past(old_idx)] != CTR_STRONG_NT);

    // R5: a not-taken outcome never leaves the counter at the top
    assert_not_taken_leaves_ceiling_R5: assert property (@(posedge clk) disable iff (rst)
        (train_en && !train_taken) |=> ctr_q[$past(old_idx)] != CTR_STRONG_T);

    // R5: saturation, a strong counter trained in its own direction stays put
    assert_saturate_top_R5: assert property (@(posedge clk) disable iff (rst)
        (train_en && train_taken && old_ctr == CTR_STRONG_T) |=> ctr_q[$past(old_idx)] == CTR_STRONG_T);

endmodule

// File: rtl/lhp_check_stage.sv
module lhp_check_stage
    import lhp_pkg::*;
#(
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_valid,
    input  logic [HIST_W-1:0] fetch_hist,
    input  logic              fetch_guess,
    output logic [HIST_W-1:0] stage_hist,
    input  ctr_t              stage_ctr,
    output logic              check_valid,
    output logic              check_taken,
    output logic              override
);
    typedef struct packed {
        logic              valid;
        logic [HIST_W-1:0] hist;
        logic              guess;
    } stage_t;

    stage_t stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q.valid <= fetch_valid;
            stage_q.hist  <= fetch_hist;
            stage_q.guess <= fetch_guess;
        end
    end

    assign stage_hist  = stage_q.hist;
    assign check_valid = stage_q.valid;
    assign check_taken = ctr_taken(stage_ctr);
    assign override    = stage_q.valid && (check_taken != stage_q.guess);

endmodule

// File: rtl/lhist_predictor.sv
module lhist_predictor
    import lhp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PC_OFS = 2,
    parameter int IDX_W  = 4,
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              fetch_guess,
    output logic              check_valid,
    output logic              check_taken,
    output logic              override,
    input  logic              resolve_valid,
    input  logic [ADDR_W-1:0] resolve_pc,
    input  logic              resolve_taken
);
    localparam int IDX_HI = PC_OFS + IDX_W;

    logic [IDX_W-1:0]  fetch_idx, res_idx;
    logic [HIST_W-1:0] fetch_hist, res_hist_old, res_hist_new, stage_hist;
    ctr_t              stage_ctr, res_ctr_old, res_ctr_trained, res_ctr_at_new;
    logic              res_guess_new;

    assign fetch_idx = fetch_pc[PC_OFS +: IDX_W];
    assign res_idx   = resolve_pc[PC_OFS +: IDX_W];

    // Address bits outside the index field are deliberately ignored.
    logic unused_pc_bits;
    assign unused_pc_bits = ^{fetch_pc[ADDR_W-1:IDX_HI], fetch_pc[PC_OFS-1:0],
                              resolve_pc[ADDR_W-1:IDX_HI], resolve_pc[PC_OFS-1:0]};

    lhp_hist_table #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (fetch_idx),
        .rd_hist  (fetch_hist),
        .rd_guess (fetch_guess),
        .up_idx   (res_idx),
        .up_hist  (res_hist_old),
        .wr_en    (resolve_valid),
        .wr_idx   (res_idx),
        .wr_taken (resolve_taken),
        .wr_guess (res_guess_new)
    );

    // Resolution: shifted history and refreshed cached prediction.
    assign res_hist_new    = {res_hist_old[HIST_W-2:0], resolve_taken};
    assign res_ctr_trained = ctr_step(res_ctr_old, resolve_taken);
    assign res_guess_new   = (res_hist_new == res_hist_old) ? ctr_taken(res_ctr_trained)
                                                            : ctr_taken(res_ctr_at_new);

    lhp_pattern_table #(.HIST_W(HIST_W)) u_pattern (
        .clk         (clk),
        .rst         (rst),
        .chk_idx     (stage_hist),
        .chk_ctr     (stage_ctr),
        .old_idx     (res_hist_old),
        .old_ctr     (res_ctr_old),
        .new_idx     (res_hist_new),
        .new_ctr     (res_ctr_at_new),
        .train_en    (resolve_valid),
        .train_taken (resolve_taken)
    );

    lhp_check_stage #(.HIST_W(HIST_W)) u_check (
        .clk         (clk),
        .rst         (rst),
        .fetch_valid (fetch_valid),
        .fetch_hist  (fetch_hist),
        .fetch_guess (fetch_guess),
        .stage_hist  (stage_hist),
        .stage_ctr   (stage_ctr),
        .check_valid (check_valid),
        .check_taken (check_taken),
        .override    (override)
    );

    // R3: check result follows each lookup by exactly one cycle
    assert_check_follows_R3: assert property (@(posedge clk) disable iff (rst)
        fetch_valid |=> check_valid);

    assert_check_only_after_lookup_R3: assert property (@(posedge clk) disable iff (rst)
        !fetch_valid |=> !check_valid);

    // R4: override only during a valid check
    assert_override_gated_R4: assert property (@(posedge clk) disable iff (rst)
        override |-> check_valid);

    // R4: override flags disagreement with the earlier guess
    assert_override_mismatch_R4: assert property (@(posedge clk) disable iff (rst)
        check_valid |-> (override == (check_taken != $past(fetch_guess))));

endmodule

// File: tb/lhist_predictor_test.sv
module lhist_predictor_test;
    localparam int ADDR_W = 32;
    localparam int PC_OFS = 2;
    localparam int IDX_W  = 4;
    localparam int HIST_W = 4;
    localparam int NIDX   = 1 << IDX_W;
    localparam int NHIST  = 1 << HIST_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              fetch_valid = 1'b0;
    logic [ADDR_W-1:0] fetch_pc = '0;
    logic              fetch_guess, check_valid, check_taken, override;
    logic              resolve_valid = 1'b0;
    logic [ADDR_W-1:0] resolve_pc = '0;
    logic              resolve_taken = 1'b0;

    always #4 clk = ~clk;

    lhist_predictor #(.ADDR_W(ADDR_W), .PC_OFS(PC_OFS), .IDX_W(IDX_W), .HIST_W(HIST_W)) uut (
        .clk(clk), .rst(rst),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .fetch_guess(fetch_guess),
        .check_valid(check_valid), .check_taken(check_taken), .override(override),
        .resolve_valid(resolve_valid), .resolve_pc(resolve_pc), .resolve_taken(resolve_taken)
    );

    // Arithmetic model of the tables
    int hist_m [NIDX];
    int cb_m   [NIDX];
    int ctr_m  [NHIST];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] step_lfsr(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    function automatic logic [ADDR_W-1:0] make_pc(input int idx, input logic [15:0] r);
        return (ADDR_W'(r) << (PC_OFS + IDX_W)) | (ADDR_W'(idx) << PC_OFS) | ADDR_W'(r[1:0]);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NIDX; i++) begin hist_m[i] = 0; cb_m[i] = 0; end
        for (int i = 0; i < NHIST; i++) ctr_m[i] = 1;
    endtask

    task automatic model_resolve(input int idx, input bit taken);
        int h, c, nh;
        h = hist_m[idx];
        c = ctr_m[h];
        if (taken) c = (c == 3) ? 3 : c + 1;
        else       c = (c == 0) ? 0 : c - 1;
        ctr_m[h] = c;
        nh = ((h * 2) + (taken ? 1 : 0)) % NHIST;
        hist_m[idx] = nh;
        cb_m[idx] = ctr_m[nh] / 2;
    endtask

    task automatic lookup(input int idx, input logic [15:0] r, input string tag);
        int exp_guess, exp_chk;
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_pc = make_pc(idx, r);
        #1;
        exp_guess = cb_m[idx];
        exp_chk = ctr_m[hist_m[idx]] / 2;
        chk(fetch_guess == exp_guess[0], {tag, " guess"}, int'(fetch_guess), exp_guess);
        @(negedge clk);
        fetch_valid = 1'b0;
        #1;
        chk(check_valid == 1'b1, {tag, " check_valid"}, int'(check_valid), 1);
        chk(check_taken == exp_chk[0], {tag, " check_taken"}, int'(check_taken), exp_chk);
        chk(override == (exp_chk != exp_guess), {tag, " override"}, int'(override),
            int'(exp_chk != exp_guess));
    endtask

    task automatic resolve(input int idx, input bit taken, input logic [15:0] r);
        @(negedge clk);
        resolve_valid = 1'b1;
        resolve_pc = make_pc(idx, r);
        resolve_taken = taken;
        @(negedge clk);
        resolve_valid = 1'b0;
        model_resolve(idx, taken);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: nothing valid out of reset
        chk(check_valid == 1'b0, "R1 check_valid after reset", int'(check_valid), 0);
        chk(override == 1'b0, "R1 override after reset", int'(override), 0);
        for (int i = 0; i < NIDX; i++) lookup(i, 16'(i * 37), "R1");

        // R3: check_valid drops one cycle after the lookup stops
        @(negedge clk); #1;
        chk(check_valid == 1'b0, "R3 check_valid idle", int'(check_valid), 0);

        // R6 R8: one branch taken repeatedly walks its history up to all ones
        for (int k = 0; k < 6; k++) begin
            resolve(3, 1'b1, 16'(k));
            lookup(3, 16'(k * 91), "R8");
        end
        // R7 R5: not-taken trains the strong counter at history 1111 down one step
        resolve(3, 1'b0, 16'h5);
        lookup(3, 16'h77, "R7");

        // R9 R4: branch 5 still has history 0, whose counter branch 3 pushed to taken
        lookup(5, 16'h1234, "R4 R9 alias override");
        chk(override == 1'b1, "R4 override expected high", int'(override), 1);

        // R8 bypass: history stays 0 after a not-taken from history 0
        resolve(5, 1'b0, 16'h9);
        lookup(5, 16'h4321, "R8 same-history refresh");

        // R5: floor saturation at 00, a later taken must give 01 (not-taken)
        for (int k = 0; k < 3; k++) resolve(6, 1'b0, 16'(k));
        resolve(7, 1'b1, 16'h3);
        lookup(8, 16'h0F0F, "R5 floor saturation");
        chk(check_taken == 1'b0, "R5 counter 01 predicts not-taken", int'(check_taken), 0);

        // R2: upper and offset address bits do not change the selected entry
        for (int k = 0; k < 8; k++) lookup(3, 16'(k * 4099 + 1), "R2");

        // Sweep: interleaved resolutions and lookups over every entry
        for (int n = 0; n < 4000; n++) begin
            lfsr = step_lfsr(lfsr);
            if (lfsr[0]) resolve(int'(lfsr[4:1]), lfsr[7] ^ lfsr[9], lfsr);
            else         lookup(int'(lfsr[4:1]), lfsr, "R3 R5 R6 R7 R8 sweep");
        end

        // R1: a second reset returns everything to its initial state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        model_reset();
        for (int i = 0; i < NIDX; i++) lookup(i, 16'(i * 5 + 3), "R1 re-reset");

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            chk(1'b0, "watchdog", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule